// File: doc/BRIEF.md
# Offload Engine Wrapper with Bus-Mastering Copy Unit

This block lets a host processor hand one function to a hardware engine. The host programs a job through a small register window on a peripheral bus: where the input words sit, where the results go, and how many words there are. It then sets a start bit. From then on the wrapper asks for the system memory bus, fetches the input words into a local buffer, starts the engine, and stores each result word back to memory. When the last result word has been accepted, it gives the bus back and raises the done bit, which can drive an interrupt line.

The engine is a stub. After a start pulse it walks the buffer one word per cycle and adds a fixed constant `INC` to each word, then reports completion. Memory is reached through a simple request/acknowledge port. The host side owns the arbitration: the wrapper raises a request and waits until it sees the grant. Job parameters can be changed between jobs but are frozen while a job runs.

Top module: `acc_wrap`

## Requirements
- R1: After reset every register reads 0, `irq` and `bus_req` are low. The word-aligned offsets are 0x00 source address, 0x04 destination address, 0x08 word count, 0x0C control (bit 0 start, write-only and read as 0; bit 1 interrupt enable) and 0x10 status (bit 0 busy, bit 1 done). The address, count and enable fields read back what was written.
- R2: A word count above `DEPTH` is stored as `DEPTH`, and a job then moves exactly `DEPTH` words.
- R3: After a start the wrapper raises `bus_req` and issues no memory request until `bus_gnt` is high.
- R4: The fetch phase reads `count` words at consecutive word addresses, starting at the source address and rising by 4.
- R5: Result word i equals input word i plus `INC` (modulo 2^32). It is written to destination + 4*i, and no other location is written.
- R6: `bus_req` falls in the cycle after the final write beat is acknowledged, and the done bit is set on that same edge.
- R7: The done bit is sticky until software writes 1 to status bit 1. `irq` is high while done and interrupt enable are both set, and clearing done drops `irq`.
- R8: With interrupt enable at 0, a job still sets the done bit, but `irq` stays low.
- R9: While busy, writes to start, source, destination and count have no effect. The running job keeps its parameters, and no second job follows.
- R10: A start with count 0 sets done on the second clock edge after the start write, and `bus_req` never rises.
- R11: Status busy reads 1 from the cycle after the start write until done is set, and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register port write |
| paddr | input | PADDR_W | Register byte address |
| pwdata | input | DATA_W | Register write data |
| prdata | output | DATA_W | Register read data |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Memory bus ownership request |
| bus_gnt | input | 1 | Memory bus ownership grant |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory transfer accepted |

## Verification
A sequencer stuck in a non-idle state would show up as `bus_req` held high and the busy bit never clearing. A job that never finishes would end the wait for done through the bench's timeout. A word index that is off by one would show up as the wrong word count on the memory port, or as a result written to the wrong address. The per-beat address monitor catches the first wrong beat at the cycle it is acknowledged. A wrong done or interrupt path would show at the status read and on `irq` within one cycle of the final write beat. A parameter register that escapes the busy freeze would show at once when it is read back during the job.

// File: rtl/acc_wrap_pkg.sv
`timescale 1ns/1ps
package acc_wrap_pkg;

  // word index of each register inside the window (byte address bits [4:2])
  localparam logic [2:0] RIX_SRC  = 3'd0;
  localparam logic [2:0] RIX_DST  = 3'd1;
  localparam logic [2:0] RIX_CNT  = 3'd2;
  localparam logic [2:0] RIX_CTRL = 3'd3;
  localparam logic [2:0] RIX_STAT = 3'd4;

  // control / status bit positions
  localparam int CTRL_GO  = 0;
  localparam int CTRL_IEN = 1;
  localparam int STAT_BSY = 0;
  localparam int STAT_DNE = 1;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ARB,
    SQ_FETCH,
    SQ_KICK,
    SQ_CALC,
    SQ_STORE
  } seq_st_t;

endpackage

// File: rtl/acc_wrap_regs.sv
`timescale 1ns/1ps
module acc_wrap_regs
  import acc_wrap_pkg::*;
#(
  parameter int PADDR_W = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 16,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0]  pwdata,
  output logic [DATA_W-1:0]  prdata,
  input  logic               seq_busy,
  input  logic               job_done,
  output logic [ADDR_W-1:0]  src_addr,
  output logic [ADDR_W-1:0]  dst_addr,
  output logic [CNT_W-1:0]   word_cnt,
  output logic               go_pulse,
  output logic               busy,
  output logic               done_bit,
  output logic               irq
);

  logic [ADDR_W-1:0] src_q, src_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ien_q, ien_d;
  logic              go_q, go_d;
  logic              dne_q, dne_d;
  logic              wr_acc;
  logic              in_win;
  logic [2:0]        rix;

  assign rix    = paddr[4:2];
  assign in_win = (paddr[1:0] == 2'b00) && (paddr[PADDR_W-1:5] == '0);
  assign wr_acc = psel && penable && pwrite && in_win;
  assign busy   = seq_busy || go_q;

  // next state
  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    cnt_d = cnt_q;
    ien_d = ien_q;
    go_d  = 1'b0;
    dne_d = dne_q;
    if (wr_acc) begin
      unique case (rix)
        RIX_SRC:  if (!busy) src_d = pwdata[ADDR_W-1:0];
        RIX_DST:  if (!busy) dst_d = pwdata[ADDR_W-1:0];
        RIX_CNT:  if (!busy) cnt_d = (pwdata > DATA_W'(DEPTH)) ? CNT_W'(DEPTH)
                                                               : pwdata[CNT_W-1:0];
        RIX_CTRL: begin
          ien_d = pwdata[CTRL_IEN];
          go_d  = pwdata[CTRL_GO] && !busy;
        end
        RIX_STAT: if (pwdata[STAT_DNE]) dne_d = 1'b0;
        default:  ;
      endcase
    end
    if (job_done) dne_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      ien_q <= 1'b0;
      go_q  <= 1'b0;
      dne_q <= 1'b0;
    end else begin
      src_q <= src_d;
      dst_q <= dst_d;
      cnt_q <= cnt_d;
      ien_q <= ien_d;
      go_q  <= go_d;
      dne_q <= dne_d;
    end
  end

  // read mux
  always_comb begin
    prdata = '0;
    if (in_win) begin
      unique case (rix)
        RIX_SRC:  prdata = DATA_W'(src_q);
        RIX_DST:  prdata = DATA_W'(dst_q);
        RIX_CNT:  prdata = DATA_W'(cnt_q);
        RIX_CTRL: prdata[CTRL_IEN] = ien_q;
        RIX_STAT: begin
          prdata[STAT_BSY] = busy;
          prdata[STAT_DNE] = dne_q;
        end
        default:  prdata = '0;
      endcase
    end
  end

  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign word_cnt = cnt_q;
  assign go_pulse = go_q;
  assign done_bit = dne_q;
  assign irq      = dne_q && ien_q;

endmodule

// File: rtl/acc_wrap_seq.sv
`timescale 1ns/1ps
module acc_wrap_seq
  import acc_wrap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [CNT_W-1:0]  word_cnt,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_idx,
  output logic [DATA_W-1:0] buf_wdata,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              core_go,
  input  logic              core_done,
  output logic              seq_busy,
  output logic              job_done
);

  localparam int BYTE_SH = 2;

  seq_st_t          st_q, st_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             last;
  logic             beat;
  logic [ADDR_W-1:0] ofs;

  assign last = (idx_q == word_cnt - CNT_W'(1));
  assign ofs  = ADDR_W'(idx_q) << BYTE_SH;
  assign beat = mem_req && mem_ack;

  // next state and outputs
  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = src_addr + ofs;
    mem_wdata = buf_rdata;
    buf_we    = 1'b0;
    buf_idx   = idx_q[IDX_W-1:0];
    buf_wdata = mem_rdata;
    core_go   = 1'b0;
    job_done  = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (go) begin
          idx_d = '0;
          if (word_cnt == '0) job_done = 1'b1;
          else                st_d     = SQ_ARB;
        end
      end
      SQ_ARB: if (bus_gnt) st_d = SQ_FETCH;
      SQ_FETCH: begin
        mem_req = bus_gnt;
        buf_we  = beat;
        if (beat) begin
          if (last) begin
            idx_d = '0;
            st_d  = SQ_KICK;
          end else begin
            idx_d = idx_q + CNT_W'(1);
          end
        end
      end
      SQ_KICK: begin
        core_go = 1'b1;
        st_d    = SQ_CALC;
      end
      SQ_CALC: if (core_done) st_d = SQ_STORE;
      SQ_STORE: begin
        mem_req  = bus_gnt;
        mem_we   = 1'b1;
        mem_addr = dst_addr + ofs;
        if (beat) begin
          if (last) begin
            idx_d    = '0;
            st_d     = SQ_IDLE;
            job_done = 1'b1;
          end else begin
            idx_d = idx_q + CNT_W'(1);
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign seq_busy = (st_q != SQ_IDLE);
  assign bus_req  = seq_busy;

endmodule

// File: rtl/acc_wrap_core.sv
`timescale 1ns/1ps
module acc_wrap_core #(
  parameter int              DATA_W = 32,
  parameter int              DEPTH  = 16,
  parameter int              CNT_W  = $clog2(DEPTH + 1),
  parameter int              IDX_W  = $clog2(DEPTH),
  parameter logic [DATA_W-1:0] INC  = 32'h0001_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CNT_W-1:0]  word_cnt,
  input  logic              ext_we,
  input  logic [IDX_W-1:0]  ext_idx,
  input  logic [DATA_W-1:0] ext_wdata,
  output logic [DATA_W-1:0] ext_rdata,
  output logic              done
);

  logic [DATA_W-1:0] buf_q [DEPTH];
  logic              run_q, run_d;
  logic [CNT_W-1:0]  pos_q, pos_d;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_val;
  logic              at_end;

  assign at_end = (pos_q == word_cnt - CNT_W'(1));
  assign done   = run_q && at_end;

  // buffer write port: engine has it while running, sequencer otherwise
  always_comb begin
    wr_en  = ext_we || run_q;
    wr_idx = run_q ? pos_q[IDX_W-1:0] : ext_idx;
    wr_val = run_q ? (buf_q[pos_q[IDX_W-1:0]] + INC) : ext_wdata;
  end

  // engine next state
  always_comb begin
    run_d = run_q;
    pos_d = pos_q;
    if (go) begin
      run_d = 1'b1;
      pos_d = '0;
    end else if (run_q) begin
      if (at_end) run_d = 1'b0;
      else        pos_d = pos_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pos_q <= '0;
    end else begin
      run_q <= run_d;
      pos_q <= pos_d;
    end
  end

  // data storage, no reset
  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (wr_en && (wr_idx == IDX_W'(e))) buf_q[e] <= wr_val;
    end
  end

  assign ext_rdata = buf_q[ext_idx];

endmodule

// File: rtl/acc_wrap.sv
`timescale 1ns/1ps
module acc_wrap #(
  parameter int                PADDR_W = 8,
  parameter int                ADDR_W  = 32,
  parameter int                DATA_W  = 32,
  parameter int                DEPTH   = 16,
  parameter logic [DATA_W-1:0] INC     = 32'h0001_0003
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0]  pwdata,
  output logic [DATA_W-1:0]  prdata,
  output logic               irq,
  output logic               bus_req,
  input  logic               bus_gnt,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_ack
);

  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int SYNC_N = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_N-1:0] rst_pipe_q;
  logic              rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[SYNC_N-1];

  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [CNT_W-1:0]  word_cnt;
  logic              go_pulse, busy, done_bit, seq_busy, job_done;
  logic              buf_we, core_go, core_done;
  logic [IDX_W-1:0]  buf_idx;
  logic [DATA_W-1:0] buf_wdata, buf_rdata;

  acc_wrap_regs #(
    .PADDR_W(PADDR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .seq_busy(seq_busy), .job_done(job_done),
    .src_addr(src_addr), .dst_addr(dst_addr), .word_cnt(word_cnt),
    .go_pulse(go_pulse), .busy(busy), .done_bit(done_bit), .irq(irq)
  );

  acc_wrap_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_s), .go(go_pulse),
    .src_addr(src_addr), .dst_addr(dst_addr), .word_cnt(word_cnt),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .core_go(core_go), .core_done(core_done),
    .seq_busy(seq_busy), .job_done(job_done)
  );

  acc_wrap_core #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W), .INC(INC)
  ) u_core (
    .clk(clk), .rst_n(rst_n_s), .go(core_go), .word_cnt(word_cnt),
    .ext_we(buf_we), .ext_idx(buf_idx), .ext_wdata(buf_wdata),
    .ext_rdata(buf_rdata), .done(core_done)
  );

endmodule

// File: rtl/acc_wrap_chk.sv
`timescale 1ns/1ps
module acc_wrap_chk #(
  parameter int PADDR_W = 8,
  parameter int ADDR_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [PADDR_W-1:0] paddr,
  input logic               bus_req,
  input logic               bus_gnt,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_ack,
  input logic               irq,
  input logic               busy,
  input logic               done_bit,
  input logic [ADDR_W-1:0]  src_addr
);

  logic src_wr;
  assign src_wr = psel && penable && pwrite && (paddr == '0);

  // R3
  xfer_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (bus_req && bus_gnt));

  // R6
  req_drop_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(mem_req && mem_we && mem_ack));

  // R6
  done_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_bit) |-> !bus_req);

  // R9
  src_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && src_wr) |=> $stable(src_addr));

  // R7
  irq_after_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !busy);

endmodule

bind acc_wrap acc_wrap_chk #(.PADDR_W(PADDR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s),
  .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
  .bus_req(bus_req), .bus_gnt(bus_gnt),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .irq(irq), .busy(busy), .done_bit(done_bit), .src_addr(src_addr)
);

// File: tb/test_acc_wrap.sv
`timescale 1ns/1ps
module test_acc_wrap;

  localparam logic [31:0] K_INC  = 32'h0001_0003;
  localparam int          K_DEPTH = 16;
  localparam logic [7:0]  A_SRC  = 8'h00;
  localparam logic [7:0]  A_DST  = 8'h04;
  localparam logic [7:0]  A_CNT  = 8'h08;
  localparam logic [7:0]  A_CTRL = 8'h0C;
  localparam logic [7:0]  A_STAT = 8'h10;

  logic        clk;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic        irq, bus_req, bus_gnt;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  acc_wrap i_acc_wrap (
    .clk(clk), .rst_n(rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // memory model: one-cycle acknowledge
  logic [31:0] mem [64];
  always @(posedge clk) begin
    mem_ack   <= mem_req && !mem_ack;
    mem_rdata <= mem[mem_addr[7:2]];
    if (mem_req && mem_we && !mem_ack) mem[mem_addr[7:2]] <= mem_wdata;
  end

  // host arbiter with programmable grant delay
  int gnt_delay = 0;
  int gnt_cnt   = 0;
  always @(posedge clk) begin
    if (!bus_req) begin
      bus_gnt <= 1'b0;
      gnt_cnt <= 0;
    end else if (gnt_cnt >= gnt_delay) begin
      bus_gnt <= 1'b1;
    end else begin
      gnt_cnt <= gnt_cnt + 1;
    end
  end

  // port monitor, sampled mid-cycle
  int   cyc = 0;
  int   nogrant = 0, rd_beats = 0, wr_beats = 0, rd_bad = 0, wr_bad = 0;
  int   last_wr_cyc = 0, fell_cyc = 0;
  bit   req_seen = 0, prev_req = 0;
  logic [31:0] exp_rd, exp_wr;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (mem_req && !bus_gnt) nogrant = nogrant + 1;
      if (bus_req) req_seen = 1;
      if (mem_req && mem_ack && !mem_we) begin
        if (mem_addr !== exp_rd) rd_bad = rd_bad + 1;
        exp_rd   = exp_rd + 4;
        rd_beats = rd_beats + 1;
      end
      if (mem_req && mem_ack && mem_we) begin
        if (mem_addr !== exp_wr) wr_bad = wr_bad + 1;
        exp_wr      = exp_wr + 4;
        wr_beats    = wr_beats + 1;
        last_wr_cyc = cyc;
      end
      if (prev_req && !bus_req) fell_cyc = cyc;
      prev_req = bus_req;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic clr_mon(input logic [31:0] rd0, input logic [31:0] wr0);
    nogrant = 0; rd_beats = 0; wr_beats = 0; rd_bad = 0; wr_bad = 0;
    req_seen = 0; last_wr_cyc = 0; fell_cyc = 0;
    exp_rd = rd0; exp_wr = wr0;
  endtask

  task automatic wait_done(output bit got);
    logic [31:0] s;
    got = 0;
    for (int i = 0; i < 400; i++) begin
      apb_rd(A_STAT, s);
      if (s[1]) begin
        got = 1;
        break;
      end
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    apb_rd(A_STAT, v);  chk_eq("R1 status after reset", v, 32'h0);
    apb_rd(A_SRC, v);   chk_eq("R1 src after reset", v, 32'h0);
    apb_rd(A_CNT, v);   chk_eq("R1 count after reset", v, 32'h0);
    chk_eq("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk_eq("R1 bus_req after reset", {31'b0, bus_req}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    apb_wr(A_SRC, 32'h0000_0040);
    apb_wr(A_DST, 32'h0000_0080);
    apb_wr(A_CNT, 32'd4);
    apb_wr(A_CTRL, 32'h2);
    apb_rd(A_SRC, v);  chk_eq("R1 src readback", v, 32'h40);
    apb_rd(A_DST, v);  chk_eq("R1 dst readback", v, 32'h80);
    apb_rd(A_CNT, v);  chk_eq("R1 count readback", v, 32'd4);
    apb_rd(A_CTRL, v); chk_eq("R1 ctrl readback, start reads 0", v, 32'h2);
    apb_wr(A_CNT, 32'd20);
    apb_rd(A_CNT, v);  chk_eq("R2 count clamped", v, K_DEPTH);
    apb_wr(A_CNT, 32'd4);
  endtask

  task automatic t_job_basic;
    logic [31:0] v;
    bit got;
    for (int i = 0; i < 4; i++) mem[16+i] = 32'hA5A5_0000 + 32'(i * 7);
    mem[36] = 32'hDEAD_BEEF;
    mem[31] = 32'hCAFE_F00D;
    gnt_delay = 3;
    clr_mon(32'h40, 32'h80);
    apb_wr(A_CTRL, 32'h3);
    apb_rd(A_STAT, v);  chk_eq("R11 busy during job", v & 32'h3, 32'h1);
    wait_done(got);
    check(got, "R6 job finished", {31'b0, got}, 32'h1);
    chk_eq("R3 no transfer before grant", nogrant, 0);
    chk_eq("R4 fetch beat count", rd_beats, 4);
    chk_eq("R4 fetch addresses", rd_bad, 0);
    chk_eq("R5 store addresses", wr_bad, 0);
    for (int i = 0; i < 4; i++)
      chk_eq("R5 result word", mem[32+i], 32'hA5A5_0000 + 32'(i * 7) + K_INC);
    chk_eq("R5 word past dst untouched", mem[36], 32'hDEAD_BEEF);
    chk_eq("R6 bus_req falls one cycle after last store", fell_cyc - last_wr_cyc, 1);
    chk_eq("R7 irq with done and enable", {31'b0, irq}, 32'h1);
    apb_rd(A_STAT, v);  chk_eq("R11 busy clear, done set", v & 32'h3, 32'h2);
    repeat (5) @(negedge clk);
    apb_rd(A_STAT, v);  chk_eq("R7 done sticky", v & 32'h3, 32'h2);
    apb_wr(A_STAT, 32'h2);
    apb_rd(A_STAT, v);  chk_eq("R7 done cleared by W1C", v & 32'h3, 32'h0);
    chk_eq("R7 irq dropped on clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_job_full_noirq;
    logic [31:0] v;
    bit got;
    for (int i = 0; i < 16; i++) mem[16+i] = 32'h1357_0000 ^ 32'(i * 32'h0101);
    gnt_delay = 0;
    apb_wr(A_DST, 32'h0);
    apb_wr(A_CNT, 32'd40);
    clr_mon(32'h40, 32'h0);
    apb_wr(A_CTRL, 32'h1);
    wait_done(got);
    check(got, "R8 job finished", {31'b0, got}, 32'h1);
    chk_eq("R2 clamped fetch beats", rd_beats, K_DEPTH);
    chk_eq("R2 clamped store beats", wr_beats, K_DEPTH);
    chk_eq("R5 store addresses full job", wr_bad, 0);
    for (int i = 0; i < 16; i++)
      chk_eq("R5 full job result", mem[i], (32'h1357_0000 ^ 32'(i * 32'h0101)) + K_INC);
    chk_eq("R8 irq stays low when disabled", {31'b0, irq}, 32'h0);
    apb_rd(A_STAT, v);  chk_eq("R8 done set without irq", v & 32'h3, 32'h2);
    apb_wr(A_STAT, 32'h2);
  endtask

  task automatic t_start_while_busy;
    logic [31:0] v;
    bit got;
    for (int i = 0; i < 8; i++) mem[16+i] = 32'h0BAD_0000 + 32'(i);
    gnt_delay = 30;
    apb_wr(A_DST, 32'h80);
    apb_wr(A_CNT, 32'd8);
    clr_mon(32'h40, 32'h80);
    apb_wr(A_CTRL, 32'h3);
    apb_wr(A_SRC, 32'hC0);
    apb_wr(A_CNT, 32'd2);
    apb_wr(A_CTRL, 32'h3);
    apb_rd(A_SRC, v);  chk_eq("R9 src frozen while busy", v, 32'h40);
    apb_rd(A_CNT, v);  chk_eq("R9 count frozen while busy", v, 32'd8);
    wait_done(got);
    check(got, "R9 job finished", {31'b0, got}, 32'h1);
    req_seen = 0;
    repeat (40) @(negedge clk);
    chk_eq("R9 no second job", {31'b0, req_seen}, 32'h0);
    chk_eq("R9 fetch beats of first job", rd_beats, 8);
    chk_eq("R9 store beats of first job", wr_beats, 8);
    chk_eq("R9 fetch addresses of first job", rd_bad, 0);
    for (int i = 0; i < 8; i++)
      chk_eq("R9 first job results", mem[32+i], 32'h0BAD_0000 + 32'(i) + K_INC);
    apb_wr(A_STAT, 32'h2);
  endtask

  task automatic t_zero_count;
    logic [31:0] v;
    apb_wr(A_CNT, 32'd0);
    clr_mon(32'h40, 32'h80);
    apb_wr(A_CTRL, 32'h3);
    chk_eq("R10 done not yet at first edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk_eq("R10 irq after second edge", {31'b0, irq}, 32'h1);
    apb_rd(A_STAT, v);  chk_eq("R10 done without busy", v & 32'h3, 32'h2);
    repeat (10) @(negedge clk);
    chk_eq("R10 bus never requested", {31'b0, req_seen}, 32'h0);
    apb_wr(A_STAT, 32'h2);
  endtask

  bit finished = 0;

  initial begin
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    bus_gnt = 0; mem_ack = 0; mem_rdata = '0;
    exp_rd = '0; exp_wr = '0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_job_basic();
    t_job_full_noirq();
    t_start_while_busy();
    t_zero_count();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule